// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 interface. It takes the device from system reset to a usable state without help from outside. A short active-low system reset pulse is enough to start it. The block then produces and times the memory's own reset, holds the clock enable low for the power-up period, and waits the exit-reset interval. It then loads the four mode registers in the order the device needs, starts a long ZQ calibration and waits for it to finish. At that point it raises a ready flag, which stays high until the next system reset.

Every wait is a cycle count derived at elaboration from the command-clock period `CK_PS`, in picoseconds. The exit-reset wait also depends on the device density. A fast power-up parameter shrinks the combined reset and clock-enable-low time from about 700 µs to 1 µs, so that simulations stay short. The mode-register 0 and mode-register 2 contents are computed from the clock period, so the CAS latency, CAS write latency and write-recovery fields are always legal for that period. All command, bank and address outputs leave registers and always carry defined values.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_ni` is low, `ddr_rst_n`, `ddr_cke` and `init_done` are 0 and the bus shows Deselect. After release, `ddr_rst_n` stays low for at least RST cycles and rises within RST+4 cycles. `ddr_cke` is never 1 while `ddr_rst_n` is 0.
- R2: `ddr_cke` rises exactly CKE cycles after `ddr_rst_n` rises.
- R3: The reset-low and clock-enable-low lengths are set by `FAST_POWERUP`. When it is 1, RST = CKE = ceil(500000/CK_PS). When it is 0, RST = ceil(200000000/CK_PS) and CKE = ceil(500000000/CK_PS).
- R4: In the cycle `ddr_cke` rises, the command is NOP or Deselect. The first mode-register load appears exactly TXPR cycles after `ddr_cke` rises, and no load appears earlier.
- R5: TXPR = max(5, ceil((tRFC+10000)/CK_PS)). tRFC is 110000, 160000, 260000 or 350000 ps for `DENSITY_GB` 1, 2, 4 or 8.
- R6: Mode-register loads come in the order bank 2, 3, 1, 0, with exactly 4 cycles from one load to the next. Command codes on {cs_n,ras_n,cas_n,we_n} are: load = 0000, ZQCL = 0110, NOP = 0111, Deselect = 1111.
- R7: The load to bank 0 sets A8=1 (DLL reset), A1:0=00 (burst 8) and a write-recovery code in A11:9. WR = max(5, ceil(15000/CK_PS)), rounded up to even above 8; the code is WR-4 for 5..8, WR/2 for 10..14 and 0 for 16. The CAS latency CL is 5, 7, 9, 11 or 13 for CK_PS ≥2500, ≥1875, ≥1500, ≥1250 or below. It is coded as A6:4=(CL-4) mod 8 and A2=(CL≥12).
- R8: The load to bank 2 carries CWL-5 in A5:3, with CWL 5, 6, 7, 8 or 9 on the same period bands as R7. The load to bank 3 carries 0. The load to bank 1 carries `MR1_BITS`.
- R9: ZQCL (A10=1, other address bits 0, bank 0) appears exactly TMOD = max(12, ceil(15000/CK_PS)) cycles after the bank-0 load.
- R10: `init_done` rises exactly `TZQ_CYC` cycles after ZQCL and then stays high until `rst_ni` is asserted again, after which the whole sequence restarts.
- R11: Each command lasts one cycle. Once `ddr_cke` is high, every other cycle shows NOP with bank 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_ni | input | 1 | System reset, active low, asynchronous assert |
| ddr_rst_n | output | 1 | Memory device reset, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The hardest case to reach from the ports is the full-length power-up, where tens of thousands of idle cycles separate reset release from the first command. Checks at every phase boundary of that run must still land on the exact cycle. The bench runs a fast-power-up instance, a second fast instance at a shorter clock period and larger density, and a full-length instance side by side from one reset. This covers both power-up lengths, two tXPR values and two sets of mode-register field codes. A mid-life reset pulse after ready then forces a complete restart of the sequence.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    PH_RESET, PH_CKE_LOW, PH_XPR, PH_MR2, PH_MR3, PH_MR1, PH_MR0, PH_ZQCL, PH_DONE
  } phase_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_ZQ  = 4'b0110,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } cmd_e;

  function automatic int ceil_div(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int trfc_ps(int density_gb);
    case (density_gb)
      1:       return 110000;
      2:       return 160000;
      4:       return 260000;
      default: return 350000;
    endcase
  endfunction

  function automatic int cas_lat(int ck_ps);
    if (ck_ps >= 2500) return 5;
    if (ck_ps >= 1875) return 7;
    if (ck_ps >= 1500) return 9;
    if (ck_ps >= 1250) return 11;
    return 13;
  endfunction

  function automatic int cas_wr_lat(int ck_ps);
    if (ck_ps >= 2500) return 5;
    if (ck_ps >= 1875) return 6;
    if (ck_ps >= 1500) return 7;
    if (ck_ps >= 1250) return 8;
    return 9;
  endfunction

  function automatic int wr_code(int ck_ps);
    int wr;
    wr = max2(5, ceil_div(15000, ck_ps));
    if (wr > 8 && (wr % 2) != 0) wr = wr + 1;
    if (wr > 16) wr = 16;
    if (wr <= 8) return wr - 4;
    if (wr == 16) return 0;
    return wr / 2;
  endfunction

  function automatic logic [15:0] mr0_bits(int ck_ps);
    logic [15:0] v;
    int cl;
    cl      = cas_lat(ck_ps);
    v       = '0;
    v[11:9] = 3'(wr_code(ck_ps));
    v[8]    = 1'b1;
    v[6:4]  = 3'(cl - 4);
    v[2]    = (cl >= 12);
    return v;
  endfunction

  function automatic logic [15:0] mr2_bits(int ck_ps);
    logic [15:0] v;
    v      = '0;
    v[5:3] = 3'(cas_wr_lat(ck_ps) - 5);
    return v;
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int TW       = 8,
  parameter int INIT_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= TW'(INIT_VAL);
    else         cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3: an expired count is held until the next load
  a_r3_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load && expired) |=> expired);

  // R3: a load that is not zero takes the timer out of the expired state
  a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_ni)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
  import ddr3_init_pkg::*;
#(
  parameter int RST_CYC  = 4,
  parameter int CKE_CYC  = 4,
  parameter int TXPR_CYC = 5,
  parameter int TMRD_CYC = 4,
  parameter int TMOD_CYC = 12,
  parameter int TZQ_CYC  = 512,
  parameter int TW       = 8
) (
  input  logic   clk,
  input  logic   rst_ni,
  output phase_e phase,
  output logic   fresh
);

  phase_e        ph_q, ph_d;
  logic          fresh_q;
  logic          load;
  logic [TW-1:0] load_val;
  logic          expired;

  ddr3_init_timer #(.TW(TW), .INIT_VAL(RST_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_RESET:   if (expired) ph_d = PH_CKE_LOW;
      PH_CKE_LOW: if (expired) ph_d = PH_XPR;
      PH_XPR:     if (expired) ph_d = PH_MR2;
      PH_MR2:     if (expired) ph_d = PH_MR3;
      PH_MR3:     if (expired) ph_d = PH_MR1;
      PH_MR1:     if (expired) ph_d = PH_MR0;
      PH_MR0:     if (expired) ph_d = PH_ZQCL;
      PH_ZQCL:    if (expired) ph_d = PH_DONE;
      PH_DONE:    ph_d = PH_DONE;
      default:    ph_d = PH_RESET;
    endcase
  end

  always_comb begin
    load = (ph_d != ph_q);
    case (ph_d)
      PH_CKE_LOW:              load_val = TW'(CKE_CYC - 1);
      PH_XPR:                  load_val = TW'(TXPR_CYC - 1);
      PH_MR2, PH_MR3, PH_MR1:  load_val = TW'(TMRD_CYC - 1);
      PH_MR0:                  load_val = TW'(TMOD_CYC - 1);
      PH_ZQCL:                 load_val = TW'(TZQ_CYC - 1);
      default:                 load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_RESET;
      fresh_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      fresh_q <= load;
    end
  end

  assign phase = ph_q;
  assign fresh = fresh_q;

  // R4: bank-2 load phase is only reached from the exit-reset wait
  a_r4_mr2_after_xpr: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_MR2 && fresh_q) |-> $past(ph_q) == PH_XPR);

  // R6: strict load order 2 -> 3 -> 1 -> 0
  a_r6_mr3_after_mr2: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_MR3 && fresh_q) |-> $past(ph_q) == PH_MR2);
  a_r6_mr1_after_mr3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_MR1 && fresh_q) |-> $past(ph_q) == PH_MR3);
  a_r6_mr0_after_mr1: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_MR0 && fresh_q) |-> $past(ph_q) == PH_MR1);

  // R9: calibration follows the bank-0 load
  a_r9_zq_after_mr0: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_ZQCL && fresh_q) |-> $past(ph_q) == PH_MR0);

endmodule

// File: rtl/ddr3_init_drive.sv
module ddr3_init_drive
  import ddr3_init_pkg::*;
#(
  parameter int               ADDR_W  = 14,
  parameter int               BA_W    = 3,
  parameter logic [15:0]      MR0_VAL = '0,
  parameter logic [15:0]      MR1_VAL = '0,
  parameter logic [15:0]      MR2_VAL = '0,
  parameter logic [15:0]      MR3_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  phase_e            phase,
  input  logic              fresh,
  output logic              mem_rst_n,
  output logic              mem_cke,
  output cmd_e              cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << 10;

  logic              rst_n_d, cke_d, done_d;
  cmd_e              cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    rst_n_d = (phase != PH_RESET);
    cke_d   = (phase != PH_RESET) && (phase != PH_CKE_LOW);
    done_d  = (phase == PH_DONE);
    cmd_d   = cke_d ? CMD_NOP : CMD_DES;
    ba_d    = '0;
    addr_d  = '0;
    if (fresh) begin
      case (phase)
        PH_MR2: begin cmd_d = CMD_MRS; ba_d = BA_W'(2); addr_d = ADDR_W'(MR2_VAL); end
        PH_MR3: begin cmd_d = CMD_MRS; ba_d = BA_W'(3); addr_d = ADDR_W'(MR3_VAL); end
        PH_MR1: begin cmd_d = CMD_MRS; ba_d = BA_W'(1); addr_d = ADDR_W'(MR1_VAL); end
        PH_MR0: begin cmd_d = CMD_MRS; ba_d = BA_W'(0); addr_d = ADDR_W'(MR0_VAL); end
        PH_ZQCL: begin cmd_d = CMD_ZQ; addr_d = ZQ_ADDR; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rst_n <= 1'b0;
      mem_cke   <= 1'b0;
      cmd       <= CMD_DES;
      ba        <= '0;
      addr      <= '0;
      done      <= 1'b0;
    end else begin
      mem_rst_n <= rst_n_d;
      mem_cke   <= cke_d;
      cmd       <= cmd_d;
      ba        <= ba_d;
      addr      <= addr_d;
      done      <= done_d;
    end
  end

  // R1: clock enable never high while the device is held in reset
  a_r1_cke_low_in_reset: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_rst_n |-> !mem_cke);

  // R4: only NOP or Deselect when clock enable rises
  a_r4_idle_at_cke_rise: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_cke) |-> (cmd == CMD_NOP || cmd == CMD_DES));

  // R11: each command occupies a single cycle followed by NOP
  a_r11_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd == CMD_MRS || cmd == CMD_ZQ) |=> cmd == CMD_NOP);

  // R10: ready is sticky until reset
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> done);

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int CK_PS        = 2500,
  parameter int DENSITY_GB   = 4,
  parameter bit FAST_POWERUP = 1'b0,
  parameter int ADDR_W       = 14,
  parameter int BA_W         = 3,
  parameter int MR1_BITS     = 'h0044,
  parameter int TMRD_CYC     = 4,
  parameter int TZQ_CYC      = 512
) (
  input  logic              clk,
  input  logic              rst_ni,
  output logic              ddr_rst_n,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  localparam int RST_CYC  = FAST_POWERUP ? ceil_div(500000, CK_PS)
                                         : ceil_div(200000000, CK_PS);
  localparam int CKE_CYC  = FAST_POWERUP ? ceil_div(500000, CK_PS)
                                         : ceil_div(500000000, CK_PS);
  localparam int TXPR_CYC = max2(5, ceil_div(trfc_ps(DENSITY_GB) + 10000, CK_PS));
  localparam int TMOD_CYC = max2(12, ceil_div(15000, CK_PS));
  localparam int MAX_CYC  = max2(max2(RST_CYC, CKE_CYC), max2(max2(TXPR_CYC, TMOD_CYC),
                                 max2(TZQ_CYC, TMRD_CYC)));
  localparam int TW       = $clog2(MAX_CYC + 1) + 1;

  localparam logic [15:0] MR0_VAL = mr0_bits(CK_PS);
  localparam logic [15:0] MR2_VAL = mr2_bits(CK_PS);
  localparam logic [15:0] MR1_VAL = 16'(MR1_BITS);

  logic [1:0] sync_q;
  logic       rst_q_n;
  phase_e     phase;
  logic       fresh;
  cmd_e       cmd;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_q_n = sync_q[1];

  ddr3_init_fsm #(
    .RST_CYC (RST_CYC),  .CKE_CYC (CKE_CYC),  .TXPR_CYC (TXPR_CYC),
    .TMRD_CYC(TMRD_CYC), .TMOD_CYC(TMOD_CYC), .TZQ_CYC  (TZQ_CYC),
    .TW      (TW)
  ) u_fsm (
    .clk    (clk),
    .rst_ni (rst_q_n),
    .phase  (phase),
    .fresh  (fresh)
  );

  ddr3_init_drive #(
    .ADDR_W (ADDR_W), .BA_W (BA_W),
    .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL), .MR2_VAL(MR2_VAL), .MR3_VAL(16'h0000)
  ) u_drive (
    .clk       (clk),
    .rst_ni    (rst_q_n),
    .phase     (phase),
    .fresh     (fresh),
    .mem_rst_n (ddr_rst_n),
    .mem_cke   (ddr_cke),
    .cmd       (cmd),
    .ba        (ddr_ba),
    .addr      (ddr_addr),
    .done      (init_done)
  );

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd;

endmodule

// File: tb/ddr3_init_seq_tb.sv
module ddr3_init_seq_tb;

  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_ZQ  = 4'b0110;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1111;

  logic clk;
  logic rst_n;
  logic        rsto [3];
  logic        cke  [3];
  logic        csn  [3];
  logic        rasn [3];
  logic        casn [3];
  logic        wen  [3];
  logic [2:0]  ba   [3];
  logic [13:0] ad   [3];
  logic        done [3];

  int errs   = 0;
  int checks = 0;
  bit ended  = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  ddr3_init_seq #(.CK_PS(8000), .DENSITY_GB(2), .FAST_POWERUP(1'b1)) u_dut (
    .clk(clk), .rst_ni(rst_n), .ddr_rst_n(rsto[0]), .ddr_cke(cke[0]),
    .ddr_cs_n(csn[0]), .ddr_ras_n(rasn[0]), .ddr_cas_n(casn[0]), .ddr_we_n(wen[0]),
    .ddr_ba(ba[0]), .ddr_addr(ad[0]), .init_done(done[0]));

  ddr3_init_seq #(.CK_PS(1250), .DENSITY_GB(8), .FAST_POWERUP(1'b1)) u_dut_fast (
    .clk(clk), .rst_ni(rst_n), .ddr_rst_n(rsto[1]), .ddr_cke(cke[1]),
    .ddr_cs_n(csn[1]), .ddr_ras_n(rasn[1]), .ddr_cas_n(casn[1]), .ddr_we_n(wen[1]),
    .ddr_ba(ba[1]), .ddr_addr(ad[1]), .init_done(done[1]));

  ddr3_init_seq #(.CK_PS(8000), .DENSITY_GB(8), .FAST_POWERUP(1'b0)) u_dut_full (
    .clk(clk), .rst_ni(rst_n), .ddr_rst_n(rsto[2]), .ddr_cke(cke[2]),
    .ddr_cs_n(csn[2]), .ddr_ras_n(rasn[2]), .ddr_cas_n(casn[2]), .ddr_we_n(wen[2]),
    .ddr_ba(ba[2]), .ddr_addr(ad[2]), .init_done(done[2]));

  function automatic logic [3:0] cmd_of(int i);
    return {csn[i], rasn[i], casn[i], wen[i]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Wait for the next non-idle command; verify the idle cycles in between (R11)
  task automatic wait_cmd(int i, output int gap, output logic [3:0] c);
    bit idle_ok = 1;
    gap = 0;
    c   = C_NOP;
    while (gap < 200000) begin
      @(negedge clk);
      gap++;
      c = cmd_of(i);
      if (c != C_NOP && c != C_DES) break;
      if (c == C_NOP && (ad[i] != 0 || ba[i] != 0)) idle_ok = 0;
    end
    chk(idle_ok, "R11", $sformatf("dut%0d idle cycles carry zero bank/address", i),
        idle_ok, 1);
  endtask

  task automatic run_seq(int i, int rst_c, int cke_c, int txpr_c, int tmod_c,
                         logic [13:0] mr0, logic [13:0] mr2, logic [13:0] mr1);
    int n;
    bit ok;
    int gap;
    logic [3:0] c;
    // R1 / R3: reset-low length, clock enable held low
    n = 0; ok = 1;
    while (rsto[i] !== 1'b1 && n < rst_c + 10) begin
      @(negedge clk); n++;
      if (cke[i] !== 1'b0) ok = 0;
    end
    chk(n >= rst_c + 1 && n <= rst_c + 4, "R1/R3", $sformatf("dut%0d reset rise cycle", i),
        n, rst_c + 3);
    chk(ok, "R1", $sformatf("dut%0d cke low during reset", i), ok, 1);
    // R2 / R3: clock-enable-low length
    n = 0;
    while (cke[i] !== 1'b1 && n < cke_c + 10) begin @(negedge clk); n++; end
    chk(n == cke_c, "R2/R3", $sformatf("dut%0d cke rise after reset", i), n, cke_c);
    // R4: idle command at clock enable rise
    c = cmd_of(i);
    chk(c == C_NOP || c == C_DES, "R4", $sformatf("dut%0d cmd at cke rise", i), c, C_NOP);
    // R4 / R5 / R6 / R8: first load is bank 2 after TXPR
    wait_cmd(i, gap, c);
    chk(gap == txpr_c, "R4/R5", $sformatf("dut%0d first load gap", i), gap, txpr_c);
    chk(c == C_MRS && ba[i] == 2, "R6", $sformatf("dut%0d first load bank", i), ba[i], 2);
    chk(ad[i] == mr2, "R8", $sformatf("dut%0d bank-2 value", i), ad[i], mr2);
    wait_cmd(i, gap, c);
    chk(gap == 4 && c == C_MRS && ba[i] == 3, "R6",
        $sformatf("dut%0d second load gap/bank", i), gap * 10 + ba[i], 43);
    chk(ad[i] == 0, "R8", $sformatf("dut%0d bank-3 value", i), ad[i], 0);
    wait_cmd(i, gap, c);
    chk(gap == 4 && c == C_MRS && ba[i] == 1, "R6",
        $sformatf("dut%0d third load gap/bank", i), gap * 10 + ba[i], 41);
    chk(ad[i] == mr1, "R8", $sformatf("dut%0d bank-1 value", i), ad[i], mr1);
    wait_cmd(i, gap, c);
    chk(gap == 4 && c == C_MRS && ba[i] == 0, "R6",
        $sformatf("dut%0d fourth load gap/bank", i), gap * 10 + ba[i], 40);
    chk(ad[i] == mr0, "R7", $sformatf("dut%0d bank-0 value", i), ad[i], mr0);
    // R9: calibration
    wait_cmd(i, gap, c);
    chk(gap == tmod_c && c == C_ZQ, "R9", $sformatf("dut%0d ZQCL gap", i), gap, tmod_c);
    chk(ad[i] == 14'h0400 && ba[i] == 0, "R9", $sformatf("dut%0d ZQCL address", i),
        ad[i], 14'h0400);
    chk(done[i] == 0, "R10", $sformatf("dut%0d ready low at ZQCL", i), done[i], 0);
    // R10: ready after calibration wait, then held
    n = 0;
    while (done[i] !== 1'b1 && n < 600) begin @(negedge clk); n++; end
    chk(n == 512, "R10", $sformatf("dut%0d ready delay", i), n, 512);
    ok = 1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (done[i] !== 1'b1 || cmd_of(i) != C_NOP) ok = 0;
    end
    chk(ok, "R10", $sformatf("dut%0d ready held with NOP", i), ok, 1);
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 3; i++) begin
      chk(rsto[i] == 0 && cke[i] == 0 && done[i] == 0, "R1",
          $sformatf("dut%0d reset state", i), {rsto[i], cke[i], done[i]}, 0);
      chk(cmd_of(i) == C_DES, "R1", $sformatf("dut%0d deselect in reset", i),
          cmd_of(i), C_DES);
    end
  endtask

  task automatic t_short();   run_seq(0, 63, 63, 22, 12, 14'h0310, 14'h0000, 14'h0044); endtask
  task automatic t_fast();    run_seq(1, 400, 400, 288, 12, 14'h0D70, 14'h0018, 14'h0044); endtask
  task automatic t_full();    run_seq(2, 25000, 62500, 45, 12, 14'h0310, 14'h0000, 14'h0044); endtask

  task automatic t_restart();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done[0] == 0 && rsto[0] == 0 && cke[0] == 0, "R10", "dut0 reset clears ready",
        {done[0], rsto[0], cke[0]}, 0);
    rst_n = 1'b1;
    run_seq(0, 63, 63, 22, 12, 14'h0310, 14'h0000, 14'h0044);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    fork
      t_short();
      t_fast();
      t_full();
    join
    t_restart();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    finish_run();
  end

endmodule